// File: doc/BRIEF.md
# Time-Slot Capture-and-Insert Transfer

This block carries one byte per frame from a chosen input time slot to a chosen output time slot on a TDM serial highway with two interfaces: a PCM side and a system side. Each interface has one serial input and one serial output with an output enable. The interfaces share a bit clock and a frame sync. The block has two independent channels. Each channel picks its source slot and interface and its destination slot and interface on its own. In every frame a channel shifts the source slot into a host-visible data register. At the next frame sync that register is copied to a hold register, and the hold register is sent out in the destination slot during that frame. So a captured byte always leaves one frame after it arrived, and the host has a full frame to read it or rewrite it.

All serial pins are sampled in the core clock domain, which must run several times faster than the bit clock. Edges of the bit clock and the frame sync are found by comparing two successive samples. Each frame has 32 slots of 8 bits, sent MSB first. Inputs are sampled on the falling bit-clock edge. Outputs change after the rising edge.

The block has one framer state machine, with states HUNT and RUN. HUNT is entered at reset. It moves to RUN on the first rising edge of frame sync, and RUN is held until the next reset. Each channel has its own capture state machine with the states OFF, WAIT and SHIFT:
- OFF to WAIT: the channel is enabled and the framer is in RUN.
- WAIT to SHIFT: a falling edge samples bit 0 of the source slot.
- SHIFT to WAIT: the falling edge of the last bit commits the byte, or a frame sync aborts a partial byte.
- WAIT or SHIFT to OFF: the channel's enable is cleared.

Top module: `tsx_transfer`

## Requirements
- R1: After reset every host register reads 0 and both output enables are low.
- R2: Until the first rising edge of frame sync, no output enable goes high and no data register captures, even with a channel enabled and the bit clock running.
- R3: The host address is channel*4+field. Field 0 is the configuration: bit 0 is enable, bit 1 is the source interface and bit 2 is the destination interface, with 0 meaning PCM and 1 meaning system. Field 1 is the 5-bit source slot. Field 2 is the 5-bit destination slot. Field 3 is the data register. Unused written bits are dropped and read back as 0.
- R4: A rising frame sync makes the next falling bit-clock edge bit 0 of slot 0. The 8 bits sampled in the source slot form the byte, with the first bit as the MSB. That byte is in the data register once the slot ends.
- R5: The data register value present at a rising frame sync is driven, MSB first, into the destination slot of the frame that begins there. Output enable is high for those 8 bits.
- R6: During any bit that is not in the destination slot of an enabled channel on that interface, output enable and data are both low.
- R7: Source and destination slot and interface are selected independently. This includes transfers across interfaces and a destination slot earlier than the source slot. The two channels do not affect each other.
- R8: A host write to a data register during a frame replaces that frame's capture, whether it lands before or after it.
- R9: A disabled channel neither captures nor drives.
- R10: If both channels name the same destination slot and interface, channel 0 is driven.
- R11: A frame sync restarts slot counting at once. A byte cut short by it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tdm_bclk | input | 1 | Serial bit clock |
| tdm_fsync | input | 1 | Frame sync, rising edge starts a frame |
| pcm_rxd | input | 1 | PCM-side serial input |
| sys_rxd | input | 1 | System-side serial input |
| pcm_txd | output | 1 | PCM-side serial output |
| pcm_txen | output | 1 | PCM-side output enable |
| sys_txd | output | 1 | System-side serial output |
| sys_txen | output | 1 | System-side output enable |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 3 | Host register address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, combinational on address |

## Verification
Fixed routes are run first:
- Same-interface routes show whether bytes land in the right slot.
- Cross-interface routes, and routes whose destination comes before their source, show whether the one-frame delay comes from the hold copy and not from slot order.
- A shared destination exposes the channel priority.
- Host writes placed before and after the capture slot tell write-wins apart from plain overwrite.

Slots 0 and 31, a cut-short frame and a bit clock that runs without frame sync cover the edges of the count. Random routes, enables, writes and serial data then mix all of these, and every slot of both outputs is compared against a bench model of the registers.

// File: rtl/tsx_pkg.sv
`timescale 1ns/1ps
package tsx_pkg;

    localparam int NIF = 2;

    typedef enum logic {
        FR_HUNT = 1'b0,
        FR_RUN  = 1'b1
    } fr_state_t;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_WAIT  = 2'd1,
        CH_SHIFT = 2'd2
    } ch_state_t;

    typedef struct packed {
        logic dst_if;
        logic src_if;
        logic en;
    } ch_cfg_t;

    localparam logic [1:0] FLD_CFG  = 2'd0;
    localparam logic [1:0] FLD_SRC  = 2'd1;
    localparam logic [1:0] FLD_DST  = 2'd2;
    localparam logic [1:0] FLD_DATA = 2'd3;

endpackage

// File: rtl/tsx_framer.sv
`timescale 1ns/1ps
module tsx_framer
    import tsx_pkg::*;
#(
    parameter  int SLOTS  = 32,
    parameter  int DW     = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BIT_W  = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fsync,
    input  logic [NIF-1:0]    rxd,
    output logic              rise_p,
    output logic              fall_p,
    output logic              frame_p,
    output logic              running,
    output logic [NIF-1:0]    rxd_s,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [BIT_W-1:0]  cur_bit
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DW - 1);

    logic bclk_s, bclk_d, fs_s, fs_d;
    fr_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_s <= 1'b0;
            bclk_d <= 1'b0;
            fs_s   <= 1'b0;
            fs_d   <= 1'b0;
            rxd_s  <= '0;
        end else begin
            bclk_s <= bclk;
            bclk_d <= bclk_s;
            fs_s   <= fsync;
            fs_d   <= fs_s;
            rxd_s  <= rxd;
        end
    end

    assign rise_p  = bclk_s & ~bclk_d;
    assign fall_p  = ~bclk_s & bclk_d;
    assign frame_p = fs_s & ~fs_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_HUNT: if (frame_p) state_d = FR_RUN;
            FR_RUN:  state_d = FR_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FR_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_slot <= '0;
            cur_bit  <= '0;
        end else if (frame_p) begin
            cur_slot <= '0;
            cur_bit  <= '0;
        end else if (state_q == FR_RUN && fall_p) begin
            if (cur_bit == LAST_BIT) begin
                cur_bit  <= '0;
                cur_slot <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
            end else begin
                cur_bit <= cur_bit + 1'b1;
            end
        end
    end

    assign running = (state_q == FR_RUN);

endmodule

// File: rtl/tsx_regs.sv
`timescale 1ns/1ps
module tsx_regs
    import tsx_pkg::*;
#(
    parameter  int NCH    = 2,
    parameter  int DW     = 8,
    parameter  int SLOT_W = 5,
    localparam int ADDR_W = $clog2(NCH) + 2,
    localparam int CH_W   = ADDR_W - 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DW-1:0]                wdata,
    input  logic [NCH-1:0][DW-1:0]       data_q,
    output ch_cfg_t [NCH-1:0]            cfg,
    output logic [NCH-1:0][SLOT_W-1:0]   src_slot,
    output logic [NCH-1:0][SLOT_W-1:0]   dst_slot,
    output logic [NCH-1:0]               data_wr,
    output logic [DW-1:0]                rdata
);

    logic [CH_W-1:0] a_ch;
    logic [1:0]      a_fld;

    assign a_ch  = addr[ADDR_W-1:2];
    assign a_fld = addr[1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            src_slot <= '0;
            dst_slot <= '0;
        end else if (wr) begin
            for (int c = 0; c < NCH; c++) begin
                if (a_ch == CH_W'(c)) begin
                    unique case (a_fld)
                        FLD_CFG:  cfg[c]      <= ch_cfg_t'(wdata[2:0]);
                        FLD_SRC:  src_slot[c] <= wdata[SLOT_W-1:0];
                        FLD_DST:  dst_slot[c] <= wdata[SLOT_W-1:0];
                        FLD_DATA: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        data_wr = '0;
        rdata   = '0;
        for (int c = 0; c < NCH; c++) begin
            if (a_ch == CH_W'(c)) begin
                data_wr[c] = wr && (a_fld == FLD_DATA);
                unique case (a_fld)
                    FLD_CFG:  rdata = DW'(cfg[c]);
                    FLD_SRC:  rdata = DW'(src_slot[c]);
                    FLD_DST:  rdata = DW'(dst_slot[c]);
                    FLD_DATA: rdata = data_q[c];
                endcase
            end
        end
    end

endmodule

// File: rtl/tsx_channel.sv
`timescale 1ns/1ps
module tsx_channel
    import tsx_pkg::*;
#(
    parameter int DW     = 8,
    parameter int SLOT_W = 5,
    parameter int BIT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              fall_p,
    input  logic              frame_p,
    input  logic [NIF-1:0]    rxd_s,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic [BIT_W-1:0]  cur_bit,
    input  ch_cfg_t           cfg,
    input  logic [SLOT_W-1:0] src_slot,
    input  logic              data_wr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     data_q,
    output logic [DW-1:0]     hold_q,
    output ch_state_t         state
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW - 1);

    ch_state_t st_q, st_d;
    logic [DW-1:0] sh_q;
    logic wrote_q;
    logic rx_bit, first_hit, last_hit, shift_en, done;

    assign rx_bit    = rxd_s[cfg.src_if];
    assign first_hit = (cur_slot == src_slot) && (cur_bit == '0);
    assign last_hit  = (cur_bit == LAST_BIT);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_OFF:   if (cfg.en && running) st_d = CH_WAIT;
            CH_WAIT:  if (!cfg.en) st_d = CH_OFF;
                      else if (fall_p && first_hit && !frame_p) st_d = CH_SHIFT;
            CH_SHIFT: if (!cfg.en) st_d = CH_OFF;
                      else if (frame_p) st_d = CH_WAIT;
                      else if (fall_p && last_hit) st_d = CH_WAIT;
            default:  st_d = CH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    assign shift_en = cfg.en && fall_p && !frame_p &&
                      ((st_q == CH_WAIT && first_hit) || st_q == CH_SHIFT);
    assign done     = cfg.en && fall_p && !frame_p && last_hit && (st_q == CH_SHIFT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            data_q  <= '0;
            hold_q  <= '0;
            wrote_q <= 1'b0;
        end else begin
            if (shift_en)
                sh_q <= {sh_q[DW-2:0], rx_bit};
            if (data_wr)
                data_q <= wdata;
            else if (done && !wrote_q)
                data_q <= {sh_q[DW-2:0], rx_bit};
            if (data_wr)
                wrote_q <= 1'b1;
            else if (frame_p)
                wrote_q <= 1'b0;
            if (frame_p)
                hold_q <= data_q;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/tsx_txmux.sv
`timescale 1ns/1ps
module tsx_txmux
    import tsx_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int DW     = 8,
    parameter int SLOT_W = 5,
    parameter int BIT_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rise_p,
    input  logic                       running,
    input  logic [SLOT_W-1:0]          cur_slot,
    input  logic [BIT_W-1:0]           cur_bit,
    input  ch_cfg_t [NCH-1:0]          cfg,
    input  logic [NCH-1:0][SLOT_W-1:0] dst_slot,
    input  logic [NCH-1:0][DW-1:0]     hold,
    output logic [NIF-1:0]             txd,
    output logic [NIF-1:0]             txen
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW - 1);

    logic [NIF-1:0] hit_v, bit_v;
    logic [BIT_W-1:0] sel_bit;

    assign sel_bit = LAST_BIT - cur_bit;

    always_comb begin
        hit_v = '0;
        bit_v = '0;
        for (int i = 0; i < NIF; i++) begin
            for (int c = NCH - 1; c >= 0; c--) begin
                if (cfg[c].en && (int'(cfg[c].dst_if) == i) && (dst_slot[c] == cur_slot)) begin
                    hit_v[i] = 1'b1;
                    bit_v[i] = hold[c][sel_bit];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd  <= '0;
            txen <= '0;
        end else if (rise_p) begin
            txen <= running ? hit_v : '0;
            txd  <= running ? (hit_v & bit_v) : '0;
        end
    end

endmodule

// File: rtl/tsx_transfer.sv
`timescale 1ns/1ps
module tsx_transfer
    import tsx_pkg::*;
#(
    parameter  int NCH    = 2,
    parameter  int SLOTS  = 32,
    parameter  int DW     = 8,
    localparam int ADDR_W = $clog2(NCH) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tdm_bclk,
    input  logic              tdm_fsync,
    input  logic              pcm_rxd,
    input  logic              sys_rxd,
    output logic              pcm_txd,
    output logic              pcm_txen,
    output logic              sys_txd,
    output logic              sys_txen,
    input  logic              hst_wr,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [DW-1:0]     hst_wdata,
    output logic [DW-1:0]     hst_rdata
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(DW);

    logic rise_p, fall_p, frame_p, running;
    logic [NIF-1:0] rxd_s, txd, txen;
    logic [SLOT_W-1:0] cur_slot;
    logic [BIT_W-1:0]  cur_bit;

    ch_cfg_t [NCH-1:0]          cfg;
    logic [NCH-1:0][SLOT_W-1:0] src_slot, dst_slot;
    logic [NCH-1:0][DW-1:0]     data_q, hold_q;
    logic [NCH-1:0]             data_wr;
    ch_state_t [NCH-1:0]        ch_st;

    tsx_framer #(.SLOTS(SLOTS), .DW(DW)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (tdm_bclk),
        .fsync    (tdm_fsync),
        .rxd      ({sys_rxd, pcm_rxd}),
        .rise_p   (rise_p),
        .fall_p   (fall_p),
        .frame_p  (frame_p),
        .running  (running),
        .rxd_s    (rxd_s),
        .cur_slot (cur_slot),
        .cur_bit  (cur_bit)
    );

    tsx_regs #(.NCH(NCH), .DW(DW), .SLOT_W(SLOT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (hst_wr),
        .addr     (hst_addr),
        .wdata    (hst_wdata),
        .data_q   (data_q),
        .cfg      (cfg),
        .src_slot (src_slot),
        .dst_slot (dst_slot),
        .data_wr  (data_wr),
        .rdata    (hst_rdata)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tsx_channel #(.DW(DW), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .running  (running),
            .fall_p   (fall_p),
            .frame_p  (frame_p),
            .rxd_s    (rxd_s),
            .cur_slot (cur_slot),
            .cur_bit  (cur_bit),
            .cfg      (cfg[c]),
            .src_slot (src_slot[c]),
            .data_wr  (data_wr[c]),
            .wdata    (hst_wdata),
            .data_q   (data_q[c]),
            .hold_q   (hold_q[c]),
            .state    (ch_st[c])
        );
    end

    tsx_txmux #(.NCH(NCH), .DW(DW), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_txmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_p   (rise_p),
        .running  (running),
        .cur_slot (cur_slot),
        .cur_bit  (cur_bit),
        .cfg      (cfg),
        .dst_slot (dst_slot),
        .hold     (hold_q),
        .txd      (txd),
        .txen     (txen)
    );

    assign pcm_txd  = txd[0];
    assign pcm_txen = txen[0];
    assign sys_txd  = txd[1];
    assign sys_txen = txen[1];

endmodule

// File: rtl/tsx_transfer_chk.sv
`timescale 1ns/1ps
module tsx_transfer_chk
    import tsx_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int DW     = 8,
    parameter int SLOT_W = 5,
    parameter int BIT_W  = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   running,
    input logic                   rise_p,
    input logic                   fall_p,
    input logic                   frame_p,
    input logic [SLOT_W-1:0]      cur_slot,
    input logic [BIT_W-1:0]       cur_bit,
    input logic                   pcm_txd,
    input logic                   pcm_txen,
    input logic                   sys_txd,
    input logic                   sys_txen,
    input ch_cfg_t [NCH-1:0]      cfg,
    input ch_state_t [NCH-1:0]    ch_st,
    input logic [NCH-1:0][DW-1:0] data_q,
    input logic [NCH-1:0]         data_wr
);

    // R2
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!pcm_txen && !sys_txen));

    // R5
    tx_edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rise_p) |-> $stable({pcm_txd, pcm_txen, sys_txd, sys_txen}));

    // R11
    fs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_p |=> (running && cur_slot == '0 && cur_bit == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R9
        off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg[c].en |=> (ch_st[c] == CH_OFF));

        // R4
        data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!data_wr[c] && !fall_p) |=> $stable(data_q[c]));
    end

endmodule

bind tsx_transfer tsx_transfer_chk #(
    .NCH(NCH), .DW(DW), .SLOT_W(SLOT_W), .BIT_W(BIT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (running),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .frame_p  (frame_p),
    .cur_slot (cur_slot),
    .cur_bit  (cur_bit),
    .pcm_txd  (pcm_txd),
    .pcm_txen (pcm_txen),
    .sys_txd  (sys_txd),
    .sys_txen (sys_txen),
    .cfg      (cfg),
    .ch_st    (ch_st),
    .data_q   (data_q),
    .data_wr  (data_wr)
);

// File: tb/tsx_transfer_test.sv
`timescale 1ns/1ps
module tsx_transfer_test;

    localparam int SLOTS = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, fsync = 1'b0, pcm_rxd = 1'b0, sys_rxd = 1'b0;
    logic pcm_txd, pcm_txen, sys_txd, sys_txen;
    logic hst_wr = 1'b0;
    logic [2:0] hst_addr = '0;
    logic [7:0] hst_wdata = '0;
    logic [7:0] hst_rdata;

    int n_run = 0, n_fail = 0;

    bit m_en[2], m_sif[2], m_dif[2], m_run;
    int m_ss[2], m_ds[2];
    logic [7:0] m_data[2], m_hold[2];

    logic [7:0] rx[2][SLOTS];
    logic oe_o[2][256];
    logic d_o[2][256];

    always #2.5 clk = ~clk;

    tsx_transfer uut (
        .clk(clk), .rst_n(rst_n), .tdm_bclk(bclk), .tdm_fsync(fsync),
        .pcm_rxd(pcm_rxd), .sys_rxd(sys_rxd),
        .pcm_txd(pcm_txd), .pcm_txen(pcm_txen),
        .sys_txd(sys_txd), .sys_txen(sys_txen),
        .hst_wr(hst_wr), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic hwrite(input int ch, input int fld, input logic [7:0] v);
        @(negedge clk);
        hst_wr = 1'b1; hst_addr = 3'(ch * 4 + fld); hst_wdata = v;
        @(negedge clk);
        hst_wr = 1'b0;
        case (fld)
            0: begin m_en[ch] = v[0]; m_sif[ch] = v[1]; m_dif[ch] = v[2]; end
            1: m_ss[ch] = int'(v[4:0]);
            2: m_ds[ch] = int'(v[4:0]);
            default: m_data[ch] = v;
        endcase
    endtask

    task automatic hread_chk(input int ch, input int fld, input int exp, input string req);
        @(negedge clk);
        hst_addr = 3'(ch * 4 + fld);
        #1;
        chk(req, int'(hst_rdata), exp, $sformatf("reg ch%0d field%0d", ch, fld));
    endtask

    task automatic cfg_ch(input int ch, input bit en, input bit sif, input int ss,
                          input bit dif, input int ds);
        hwrite(ch, 0, {5'd0, dif, sif, en});
        hwrite(ch, 1, 8'(ss));
        hwrite(ch, 2, 8'(ds));
    endtask

    task automatic run_frame(input int nbits, input bit use_fs, input bit do_wr,
                             input int wr_bit, input int wr_ch, input logic [7:0] wr_val);
        for (int i = 0; i < 2; i++)
            for (int s = 0; s < SLOTS; s++)
                rx[i][s] = 8'($urandom);
        if (use_fs) begin
            @(negedge clk);
            fsync = 1'b1;
            m_run = 1'b1;
            for (int c = 0; c < 2; c++) m_hold[c] = m_data[c];
            repeat (2) @(negedge clk);
        end
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            bclk = 1'b1;
            fsync = 1'b0;
            pcm_rxd = rx[0][b / 8][7 - (b % 8)];
            sys_rxd = rx[1][b / 8][7 - (b % 8)];
            repeat (3) @(negedge clk);
            oe_o[0][b] = pcm_txen; d_o[0][b] = pcm_txd;
            oe_o[1][b] = sys_txen; d_o[1][b] = sys_txd;
            @(negedge clk);
            bclk = 1'b0;
            if (do_wr && b == wr_bit) begin
                hst_wr = 1'b1; hst_addr = 3'(wr_ch * 4 + 3); hst_wdata = wr_val;
            end
            @(negedge clk);
            hst_wr = 1'b0;
            repeat (2) @(negedge clk);
        end
        for (int i = 0; i < 2; i++) begin
            for (int s = 0; s < nbits / 8; s++) begin
                logic [7:0] ob, db, exp_b;
                int nhit, first_c;
                bit dis_hit;
                string tag;
                nhit = 0; first_c = -1; dis_hit = 1'b0;
                for (int c = 1; c >= 0; c--) begin
                    if (m_dif[c] == i[0] && m_ds[c] == s) begin
                        if (m_en[c]) begin nhit++; first_c = c; end
                        else dis_hit = 1'b1;
                    end
                end
                for (int k = 0; k < 8; k++) begin
                    ob[7 - k] = oe_o[i][s * 8 + k];
                    db[7 - k] = d_o[i][s * 8 + k];
                end
                if (!m_run) begin
                    tag = "R2"; nhit = 0;
                end else if (nhit > 1) tag = "R10";
                else if (nhit == 1 && m_sif[first_c] != m_dif[first_c]) tag = "R7";
                else if (nhit == 1) tag = "R5";
                else if (dis_hit) tag = "R9";
                else tag = "R6";
                exp_b = (nhit > 0) ? m_hold[first_c] : 8'h00;
                chk(tag, int'({ob, db}), int'({(nhit > 0) ? 8'hFF : 8'h00, exp_b}),
                    $sformatf("if%0d slot%0d {oe,data}", i, s));
            end
        end
        for (int c = 0; c < 2; c++) begin
            string tag;
            if (do_wr && wr_ch == c) begin
                m_data[c] = wr_val; tag = "R8";
            end else if (!m_run) tag = "R2";
            else if (!m_en[c]) tag = "R9";
            else if ((m_ss[c] + 1) * 8 <= nbits) begin
                m_data[c] = rx[m_sif[c]][m_ss[c]]; tag = "R4";
            end else tag = "R11";
            hread_chk(c, 3, int'(m_data[c]), tag);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got hung expected done");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            m_en[c] = 0; m_sif[c] = 0; m_dif[c] = 0; m_ss[c] = 0; m_ds[c] = 0;
            m_data[c] = '0; m_hold[c] = '0;
        end
        m_run = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", int'({pcm_txen, sys_txen}), 0, "output enables");
        for (int c = 0; c < 2; c++)
            for (int f = 0; f < 4; f++)
                hread_chk(c, f, 0, "R1");

        // R3 register layout and masking
        hwrite(1, 0, 8'hFF);
        hread_chk(1, 0, 8'h07, "R3");
        hwrite(1, 1, 8'hE9);
        hread_chk(1, 1, 8'h09, "R3");
        hwrite(1, 2, 8'h3F);
        hread_chk(1, 2, 8'h1F, "R3");
        cfg_ch(1, 0, 0, 0, 0, 0);
        hread_chk(1, 0, 0, "R3");

        // R2 bit clock running without frame sync
        cfg_ch(0, 1, 0, 0, 1, 0);
        run_frame(24, 0, 0, 0, 0, 8'h00);

        // R4 R5 R7 directed routes, cross interface and dst before src
        cfg_ch(0, 1, 0, 3, 1, 7);
        cfg_ch(1, 1, 1, 10, 0, 2);
        repeat (3) run_frame(256, 1, 0, 0, 0, 8'h00);

        // R10 shared destination
        cfg_ch(1, 1, 1, 10, 1, 7);
        repeat (2) run_frame(256, 1, 0, 0, 0, 8'h00);

        // R8 write before and after the capture slot
        cfg_ch(1, 1, 1, 10, 0, 2);
        run_frame(256, 1, 1, 5, 0, 8'hA5);
        run_frame(256, 1, 1, 200, 1, 8'h3C);
        run_frame(256, 1, 0, 0, 0, 8'h00);

        // R9 disabled channel
        cfg_ch(1, 0, 1, 10, 0, 2);
        repeat (2) run_frame(256, 1, 0, 0, 0, 8'h00);

        // R11 cut-short frame
        cfg_ch(1, 1, 1, 20, 0, 2);
        run_frame(100, 1, 0, 0, 0, 8'h00);
        run_frame(256, 1, 0, 0, 0, 8'h00);

        // R4 R5 slot boundaries
        cfg_ch(0, 1, 0, 31, 0, 0);
        cfg_ch(1, 1, 1, 31, 1, 31);
        repeat (3) run_frame(256, 1, 0, 0, 0, 8'h00);

        // random routes, enables and writes
        for (int f = 0; f < 12; f++) begin
            if ($urandom_range(2, 0) == 0) begin
                int c;
                c = int'($urandom_range(1, 0));
                cfg_ch(c, ($urandom_range(3, 0) != 0), 1'($urandom), int'($urandom_range(31, 0)),
                       1'($urandom), int'($urandom_range(31, 0)));
            end
            run_frame(256, 1, ($urandom_range(3, 0) == 0), int'($urandom_range(255, 0)),
                      int'($urandom_range(1, 0)), 8'($urandom));
        end

        finish_up();
    end

endmodule